// File: doc/BRIEF.md
# Reduced Boundary-Scan Test Access Port

This block is the serial test port of a memory device. A four-pin serial interface gives board test equipment access to the device: a test clock, a mode-select line, serial data in, and serial data out with an output enable. A sixteen-state controller follows the mode-select line. It steers the serial stream through a three-bit instruction register or through one of three data registers. The data registers are a one-bit bypass stage, a fixed 32-bit identification word, and a boundary register that captures a parallel bus of pin values. Serial data always enters at the most significant bit of the selected register and leaves from its least significant bit.

The port implements a deliberate subset of the standard scan instruction set. Five opcodes are legal. The other three are reserved and act as bypass. Two of the legal instructions also drive control flags into the memory core: one requests that the core's outputs float, and the other marks the external-test mode. The block comes out of power-on reset in its idle test state, with the identification instruction loaded and the serial output disabled.

Top module: `scan_tap`

## Requirements
- R1: `tms` and `tdi` are sampled on the rising edge of `tck`. `tdo` and `tdo_en` change only on the falling edge of `tck`.
- R2: Five consecutive rising edges of `tck` with `tms` high bring the controller to Test-Logic-Reset from any state.
- R3: While `por_n` is low, the port is in Test-Logic-Reset, `tdo_en` is 0, and both core flags are 0.
- R4: The instruction register is 3 bits wide. It holds IDCODE (001) after power-on and whenever the controller is in Test-Logic-Reset.
- R5: In Capture-IR, the instruction shift stage loads 001, so that the two low bits read 01. This value is shifted out LSB first in Shift-IR.
- R6: Bits shifted into the instruction register in Shift-IR have no effect until the controller enters Update-IR. At that edge they become the active instruction.
- R7: Under BYPASS (111), the one-bit bypass register loads 0 in Capture-DR. In Shift-DR it delays `tdi` to `tdo` by one clock.
- R8: Under IDCODE (001), Capture-DR loads the 32-bit `ID_VALUE` parameter. Shift-DR shifts it out LSB first.
- R9: Under EXTEST (000), SAMPLE/PRELOAD (100) or SAMPLE Z (010), Capture-DR loads `pin_ring` into the `BSR_LEN`-bit boundary register. Shift-DR then moves `tdi` into its MSB and presents its LSB on `tdo`.
- R10: The reserved codes 011, 101 and 110 select the bypass register and raise neither core flag.
- R11: `core_hiz` is 1 exactly while SAMPLE Z (010) is the active instruction. `extest_on` is 1 exactly while EXTEST (000) is the active instruction.
- R12: `tdo_en` is 1 only while the controller is in Shift-IR or Shift-DR. In all other states `tdo` is in high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select that steers the controller |
| tdi | input | 1 | Serial data in |
| pin_ring | input | BSR_LEN | Parallel pin values captured by the boundary register |
| tdo | output | 1 | Serial data out |
| tdo_en | output | 1 | Output enable for `tdo`; 0 means high impedance |
| core_hiz | output | 1 | Requests that the memory core float its outputs |
| extest_on | output | 1 | Marks that external test is the active instruction |

## Verification
The bench drives the serial port directly and checks when an instruction takes effect. It samples the core flags in Exit1-IR, before Update-IR. A design that applied the shift stage directly would raise `core_hiz` too early. The bench breaks off a scan in the middle of Shift-DR with five high `tms` bits; a controller that miscounts the path would leave SAMPLE Z active and the scan output enabled. Bypass and reserved-code scans check for the single leading 0 and the one-bit delay. A wrong register choice, or a missing capture, shows up as a shifted or foreign bit stream. The falling-edge check reads `tdo` just after a rising edge and again after the falling edge. An output stage clocked on the wrong edge shows the new bit half a cycle early.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int unsigned IR_BITS = 3;
    localparam int unsigned ID_BITS = 32;

    typedef enum logic [3:0] {
        ST_RESET    = 4'd0,
        ST_IDLE     = 4'd1,
        ST_SEL_DR   = 4'd2,
        ST_CAP_DR   = 4'd3,
        ST_SHIFT_DR = 4'd4,
        ST_EXIT1_DR = 4'd5,
        ST_PAUSE_DR = 4'd6,
        ST_EXIT2_DR = 4'd7,
        ST_UPD_DR   = 4'd8,
        ST_SEL_IR   = 4'd9,
        ST_CAP_IR   = 4'd10,
        ST_SHIFT_IR = 4'd11,
        ST_EXIT1_IR = 4'd12,
        ST_PAUSE_IR = 4'd13,
        ST_EXIT2_IR = 4'd14,
        ST_UPD_IR   = 4'd15
    } tap_state_e;

    typedef enum logic [IR_BITS-1:0] {
        OP_EXTEST   = 3'b000,
        OP_IDCODE   = 3'b001,
        OP_SAMPLE_Z = 3'b010,
        OP_RSVD_A   = 3'b011,
        OP_SAMPLE   = 3'b100,
        OP_RSVD_B   = 3'b101,
        OP_RSVD_C   = 3'b110,
        OP_BYPASS   = 3'b111
    } tap_op_e;

    typedef enum logic [1:0] {
        SEL_BYPASS   = 2'd0,
        SEL_IDENT    = 2'd1,
        SEL_BOUNDARY = 2'd2
    } dr_sel_e;

    // Controller transition for one rising test-clock edge
    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        tap_state_e n;
        case (s)
            ST_RESET:    n = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     n = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   n = tms ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   n = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR: n = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR: n = tms ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: n = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR: n = tms ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   n = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   n = tms ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   n = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR: n = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR: n = tms ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: n = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR: n = tms ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   n = tms ? ST_SEL_DR   : ST_IDLE;
            default:     n = ST_RESET;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state_q,
    output tap_state_e state_d
);

    typedef struct packed {
        tap_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d    = fsm_q;
        fsm_d.st = tap_next(fsm_q.st, tms);
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            fsm_q <= '{st: ST_RESET};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_q = fsm_q.st;
    assign state_d = fsm_d.st;

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic               tck,
    input  logic               por_n,
    input  logic               tdi,
    input  tap_state_e         state_q,
    input  tap_state_e         state_d,
    output logic [IR_BITS-1:0] shreg_q,
    output tap_op_e            instr_q,
    output dr_sel_e            sel,
    output logic               hiz_q,
    output logic               extest_q
);

    localparam logic [IR_BITS-1:0] CAPTURE_PATTERN = 3'b001;

    typedef struct packed {
        logic [IR_BITS-1:0] shreg;
        tap_op_e            instr;
        logic               hiz;
        logic               extest;
    } ir_t;

    ir_t ir_d, ir_q;

    always_comb begin
        ir_d = ir_q;
        case (state_q)
            ST_CAP_IR:   ir_d.shreg = CAPTURE_PATTERN;
            ST_SHIFT_IR: ir_d.shreg = {tdi, ir_q.shreg[IR_BITS-1:1]};
            default:     ir_d.shreg = ir_q.shreg;
        endcase
        // The active instruction moves only on entry to Update-IR or in reset
        if (state_d == ST_RESET) begin
            ir_d.instr = OP_IDCODE;
        end else if (state_d == ST_UPD_IR) begin
            ir_d.instr = tap_op_e'(ir_q.shreg);
        end
        ir_d.hiz    = (ir_d.instr == OP_SAMPLE_Z);
        ir_d.extest = (ir_d.instr == OP_EXTEST);
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            ir_q <= '{shreg: CAPTURE_PATTERN, instr: OP_IDCODE, hiz: 1'b0, extest: 1'b0};
        end else begin
            ir_q <= ir_d;
        end
    end

    always_comb begin
        case (ir_q.instr)
            OP_EXTEST, OP_SAMPLE, OP_SAMPLE_Z: sel = SEL_BOUNDARY;
            OP_IDCODE:                         sel = SEL_IDENT;
            default:                           sel = SEL_BYPASS;
        endcase
    end

    assign shreg_q  = ir_q.shreg;
    assign instr_q  = ir_q.instr;
    assign hiz_q    = ir_q.hiz;
    assign extest_q = ir_q.extest;

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int unsigned          BSR_LEN  = 16,
    parameter logic [ID_BITS-1:0]   ID_VALUE = 32'h2C4B_9A07
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tdi,
    input  tap_state_e         state_q,
    input  dr_sel_e            sel,
    input  logic [BSR_LEN-1:0] pins,
    output logic               dr_lsb
);

    typedef struct packed {
        logic               bypass;
        logic [ID_BITS-1:0] ident;
        logic [BSR_LEN-1:0] bsr;
    } dr_t;

    dr_t dr_d, dr_q;
    logic [BSR_LEN-1:0] bsr_shifted;

    generate
        if (BSR_LEN == 1) begin : g_single
            assign bsr_shifted = tdi;
        end else begin : g_chain
            assign bsr_shifted = {tdi, dr_q.bsr[BSR_LEN-1:1]};
        end
    endgenerate

    always_comb begin
        dr_d = dr_q;
        if (state_q == ST_CAP_DR) begin
            case (sel)
                SEL_BYPASS: dr_d.bypass = 1'b0;
                SEL_IDENT:  dr_d.ident  = ID_VALUE;
                default:    dr_d.bsr    = pins;
            endcase
        end else if (state_q == ST_SHIFT_DR) begin
            case (sel)
                SEL_BYPASS: dr_d.bypass = tdi;
                SEL_IDENT:  dr_d.ident  = {tdi, dr_q.ident[ID_BITS-1:1]};
                default:    dr_d.bsr    = bsr_shifted;
            endcase
        end
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            dr_q <= '0;
        end else begin
            dr_q <= dr_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_BYPASS: dr_lsb = dr_q.bypass;
            SEL_IDENT:  dr_lsb = dr_q.ident[0];
            default:    dr_lsb = dr_q.bsr[0];
        endcase
    end

endmodule

// File: rtl/scan_tap.sv
module scan_tap
    import scan_tap_pkg::*;
#(
    parameter int unsigned        BSR_LEN  = 16,
    parameter logic [31:0]        ID_VALUE = 32'h2C4B_9A07
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_ring,
    output logic               tdo,
    output logic               tdo_en,
    output logic               core_hiz,
    output logic               extest_on
);

    tap_state_e          fsm_state;
    tap_state_e          fsm_next;
    tap_op_e             cur_instr;
    dr_sel_e             dr_select;
    logic [IR_BITS-1:0]  ir_shreg;
    logic                dr_lsb;

    scan_tap_fsm u_fsm (
        .tck     (tck),
        .por_n   (por_n),
        .tms     (tms),
        .state_q (fsm_state),
        .state_d (fsm_next)
    );

    scan_tap_ir u_ir (
        .tck      (tck),
        .por_n    (por_n),
        .tdi      (tdi),
        .state_q  (fsm_state),
        .state_d  (fsm_next),
        .shreg_q  (ir_shreg),
        .instr_q  (cur_instr),
        .sel      (dr_select),
        .hiz_q    (core_hiz),
        .extest_q (extest_on)
    );

    scan_tap_dr #(
        .BSR_LEN  (BSR_LEN),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck     (tck),
        .por_n   (por_n),
        .tdi     (tdi),
        .state_q (fsm_state),
        .sel     (dr_select),
        .pins    (pin_ring),
        .dr_lsb  (dr_lsb)
    );

    // Falling-edge output stage
    typedef struct packed {
        logic tdo;
        logic en;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d    = out_q;
        out_d.en = (fsm_state == ST_SHIFT_IR) || (fsm_state == ST_SHIFT_DR);
        if (fsm_state == ST_SHIFT_IR) begin
            out_d.tdo = ir_shreg[0];
        end else if (fsm_state == ST_SHIFT_DR) begin
            out_d.tdo = dr_lsb;
        end
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign tdo    = out_q.tdo;
    assign tdo_en = out_q.en;

    // cur_instr is observed by the bound checker
    logic unused_instr;
    assign unused_instr = ^cur_instr;

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
    import scan_tap_pkg::*;
(
    input logic               tck,
    input logic               por_n,
    input logic               tms,
    input tap_state_e         state_q,
    input tap_op_e            instr_q,
    input logic [IR_BITS-1:0] ir_shreg,
    input logic               tdo_en,
    input logic               core_hiz,
    input logic               extest_on
);

    logic [2:0] tms_run;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            tms_run <= 3'd0;
        end else if (tms) begin
            tms_run <= (tms_run == 3'd7) ? 3'd7 : tms_run + 3'd1;
        end else begin
            tms_run <= 3'd0;
        end
    end

    assert_five_high_reset_R2: assert property (@(posedge tck) disable iff (!por_n)
        (tms && tms_run >= 3'd4) |=> (state_q == ST_RESET));

    assert_reset_holds_idcode_R4: assert property (@(posedge tck) disable iff (!por_n)
        (state_q == ST_RESET) |-> (instr_q == OP_IDCODE));

    assert_capture_ir_pattern_R5: assert property (@(posedge tck) disable iff (!por_n)
        (state_q == ST_CAP_IR) |=> (ir_shreg == 3'b001));

    assert_instr_moves_on_update_R6: assert property (@(posedge tck) disable iff (!por_n)
        !$stable(instr_q) |-> (state_q == ST_UPD_IR || state_q == ST_RESET));

    assert_flags_exclusive_R11: assert property (@(posedge tck) disable iff (!por_n)
        $onehot0({core_hiz, extest_on}));

    assert_extest_flag_match_R11: assert property (@(posedge tck) disable iff (!por_n)
        extest_on |-> (instr_q == OP_EXTEST));

    assert_tdo_en_shift_only_R12: assert property (@(posedge tck) disable iff (!por_n)
        tdo_en |-> (state_q == ST_SHIFT_IR || state_q == ST_SHIFT_DR));

endmodule

bind scan_tap scan_tap_chk chk_i (
    .tck       (tck),
    .por_n     (por_n),
    .tms       (tms),
    .state_q   (fsm_state),
    .instr_q   (cur_instr),
    .ir_shreg  (ir_shreg),
    .tdo_en    (tdo_en),
    .core_hiz  (core_hiz),
    .extest_on (extest_on)
);

// File: tb/scan_tap_tb_top.sv
module scan_tap_tb_top;

    localparam int unsigned BSR_N  = 16;
    localparam logic [31:0] ID_EXP = 32'h1A5C_E0F3;

    logic             tck = 1'b0;
    logic             por_n = 1'b0;
    logic             tms = 1'b1;
    logic             tdi = 1'b1;
    logic [BSR_N-1:0] pin_ring = '0;
    logic             tdo, tdo_en, core_hiz, extest_on;

    int compared = 0;
    int mismatched = 0;

    scan_tap #(.BSR_LEN(BSR_N), .ID_VALUE(ID_EXP)) dut_i (
        .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pin_ring(pin_ring),
        .tdo(tdo), .tdo_en(tdo_en), .core_hiz(core_hiz), .extest_on(extest_on)
    );

    always #4 tck = ~tck;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Entered and left just after a falling edge
    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic scan_ir(input logic [2:0] op, output logic [2:0] cap,
                           output logic pre_hiz, output logic pre_ext);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 3; i++) begin
            cap[i] = tdo;
            step(i == 2, op[i]);
        end
        pre_hiz = core_hiz;
        pre_ext = extest_on;
        step(1, 0);
        step(0, 0);
    endtask

    task automatic scan_dr(input logic [63:0] din, input int n,
                           output logic [63:0] dout, output logic en_ok);
        dout  = '0;
        en_ok = 1'b1;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            if (tdo_en !== 1'b1) en_ok = 1'b0;
            step(i == n - 1, din[i]);
        end
        step(1, 0);
        step(0, 0);
    endtask

    task automatic t_reset;
        chk("R3 tdo_en in reset", {63'd0, tdo_en}, 64'd0);
        chk("R3 core_hiz in reset", {63'd0, core_hiz}, 64'd0);
        chk("R3 extest_on in reset", {63'd0, extest_on}, 64'd0);
        @(negedge tck); #1;
        por_n = 1'b1;
        step(0, 0);
        chk("R12 tdo_en idle", {63'd0, tdo_en}, 64'd0);
    endtask

    task automatic t_idcode_default;
        logic [63:0] q; logic ok;
        scan_dr(64'h0, 32, q, ok);
        chk("R4 R8 idcode after power-on", q, {32'd0, ID_EXP});
        chk("R12 tdo_en during shift", {63'd0, ok}, 64'd1);
        chk("R12 tdo_en after scan", {63'd0, tdo_en}, 64'd0);
    endtask

    task automatic t_ir_capture;
        logic [2:0] c; logic ph, pe;
        scan_ir(3'b001, c, ph, pe);
        chk("R5 capture-ir pattern", {61'd0, c}, 64'd1);
    endtask

    task automatic t_bypass;
        logic [2:0] c; logic ph, pe; logic [63:0] q; logic ok;
        logic [63:0] din;
        din = 64'h1AB;
        scan_ir(3'b111, c, ph, pe);
        scan_dr(din, 9, q, ok);
        chk("R7 bypass delay", q, {din[62:0], 1'b0} & 64'h1FF);
    endtask

    task automatic t_edge;
        // R1: bypass active; tdo must move only at the falling edge
        step(1, 0); step(0, 0); step(0, 0);
        chk("R1 captured bypass bit", {63'd0, tdo}, 64'd0);
        tms = 0; tdi = 1;
        @(posedge tck); #1;
        chk("R1 tdo after rising edge", {63'd0, tdo}, 64'd0);
        @(negedge tck); #1;
        chk("R1 tdo after falling edge", {63'd0, tdo}, 64'd1);
        step(1, 0); step(1, 0); step(0, 0);
    endtask

    task automatic t_reserved;
        logic [2:0] codes [3];
        codes[0] = 3'b011; codes[1] = 3'b101; codes[2] = 3'b110;
        for (int k = 0; k < 3; k++) begin
            logic [2:0] c; logic ph, pe; logic [63:0] q; logic ok;
            scan_ir(codes[k], c, ph, pe);
            chk("R10 reserved no flags", {62'd0, core_hiz, extest_on}, 64'd0);
            scan_dr(64'h17, 5, q, ok);
            chk("R10 reserved acts as bypass", q, 64'h0E);
        end
    endtask

    task automatic t_sample;
        logic [2:0] c; logic ph, pe; logic [63:0] q; logic ok;
        logic [63:0] din;
        din = 64'h9B2D_5E71;
        pin_ring = 16'hC3A5;
        scan_ir(3'b100, c, ph, pe);
        chk("R11 sample no flags", {62'd0, core_hiz, extest_on}, 64'd0);
        scan_dr(din, 32, q, ok);
        chk("R9 sample capture and shift-through", q, {32'd0, din[15:0], 16'hC3A5});
    endtask

    task automatic t_extest;
        logic [2:0] c; logic ph, pe; logic [63:0] q; logic ok;
        pin_ring = 16'h0FF1;
        scan_ir(3'b000, c, ph, pe);
        chk("R11 extest flags", {62'd0, core_hiz, extest_on}, 64'd1);
        scan_dr(64'h0, 16, q, ok);
        chk("R9 extest captures pins", q, 64'h0FF1);
    endtask

    task automatic t_sample_z;
        logic [2:0] c; logic ph, pe; logic [63:0] q; logic ok;
        pin_ring = 16'h7E18;
        scan_ir(3'b010, c, ph, pe);
        chk("R6 flags unchanged before update-ir", {62'd0, ph, pe}, 64'd1);
        chk("R11 sample-z flags", {62'd0, core_hiz, extest_on}, 64'd2);
        scan_dr(64'h0, 16, q, ok);
        chk("R9 sample-z captures pins", q, 64'h7E18);
    endtask

    task automatic t_tms_reset;
        logic [2:0] c; logic ph, pe; logic [63:0] q; logic ok;
        scan_ir(3'b010, c, ph, pe);
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 5; i++) step(1, 0);
        chk("R2 five high tms clears sample-z", {62'd0, core_hiz, extest_on}, 64'd0);
        chk("R2 tdo_en off in reset", {63'd0, tdo_en}, 64'd0);
        step(0, 0);
        scan_dr(64'h0, 32, q, ok);
        chk("R2 R4 idcode after tms reset", q, {32'd0, ID_EXP});
    endtask

    initial begin
        #(200000 * 8);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #10;
        t_reset();
        t_idcode_default();
        t_ir_capture();
        t_bypass();
        t_edge();
        t_reserved();
        t_sample();
        t_extest();
        t_sample_z();
        t_tms_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule